// File: doc/BRIEF.md
# Endpoint Buffer Length Auto-Handler

This block keeps the byte count and the packet boundaries of a single USB endpoint buffer. It sits between a processor data port and the packet engine, and the buffer memory is held inside the block. It has two directions, chosen by a configuration input.

In the IN direction the processor streams bytes into the buffer. A packet is handed to the engine on its own once a full maximum-size packet has been written. It is also handed over when the bytes written reach the remaining transfer length. Each packet the engine sends reduces that length. When a transfer ends exactly on a full packet, a zero-length packet is queued unless that option is switched off.

In the OUT direction each packet the engine accepts loads the count. Processor reads step the count down, and the buffer frees itself when the count reaches zero. Until then further packets are refused. A short-packet flag reports whether the last accepted packet was smaller than the maximum size.

Top module: `ep_len_ctl`

## Requirements
- R1: After reset or a bus reset pulse, len_q is 0, tx_valid is 0, short_pkt is 0 and an enabled OUT endpoint has rx_nak low. A bus reset leaves the max-packet size unchanged.
- R2: A max-packet write stores min(mps_wdata, DEPTH), reloads len_q with that value and drops any pending packet or unread data. A length write replaces len_q with len_wdata.
- R3: One processor access moves 2 bytes when cfg_wide=1 and 1 byte when cfg_wide=0. A wide write stores bits 7:0 at the lower buffer address and bits 15:8 at the next one.
- R4: In the IN direction, tx_valid rises with tx_len equal to the max-packet size on the write that fills the buffer to that size. Processor writes made while tx_valid is high are ignored.
- R5: Each in_sent pulse while tx_valid is high lowers len_q by tx_len, saturating at 0. When len_q is non-zero and below the max-packet size, the packet is validated when the bytes written reach len_q, and tx_len equals len_q.
- R6: When an automatic full-size packet is sent and brings a non-zero len_q to exactly 0, a zero-length packet (tx_valid=1, tx_len=0) is queued if cfg_no_zlp=0. If cfg_no_zlp=1, tx_valid falls and nothing more is sent.
- R7: cmd_validate in the IN direction validates the bytes written so far (tx_len = that count). cmd_clear in the OUT direction empties the buffer, sets len_q to 0 and lowers rx_nak.
- R8: In the OUT direction, an accepted rx_done loads len_q with min(rx_count, max-packet size). Each processor read lowers len_q by the bytes taken. The read that brings len_q to 0 frees the buffer, so rx_nak falls.
- R9: On a wide read with one byte left, cpu_rdata carries that byte in bits 7:0 and zero in bits 15:8. cpu_rdata is 0 whenever no OUT data is held.
- R10: On every accepted rx_done, short_pkt becomes 1 if rx_count is below the max-packet size and 0 otherwise. It changes at no other time except reset.
- R11: A max-packet size of 0 disables the endpoint. tx_valid stays 0, processor writes and validates have no effect, rx_done is refused and rx_nak is 1.
- R12: While OUT data is unread, rx_nak is 1, and rx_done and engine writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst | input | 1 | USB bus reset pulse |
| cfg_dir_in | input | 1 | 1 = IN (device to host), 0 = OUT |
| cfg_no_zlp | input | 1 | 1 = no trailing zero-length packet |
| cfg_wide | input | 1 | 1 = 16-bit processor port, 0 = 8-bit |
| mps_we | input | 1 | Max-packet size write strobe |
| mps_wdata | input | PW | Max-packet size value |
| len_we | input | 1 | Buffer length write strobe |
| len_wdata | input | LW | Buffer length value |
| len_q | output | LW | Current buffer length |
| cpu_we | input | 1 | Processor data write strobe |
| cpu_wdata | input | 16 | Processor write data |
| cpu_re | input | 1 | Processor data read strobe |
| cpu_rdata | output | 16 | Processor read data at current position |
| cmd_validate | input | 1 | Manual validate of IN data |
| cmd_clear | input | 1 | Manual clear of OUT data |
| tx_valid | output | 1 | A packet waits for the next IN token |
| tx_len | output | PW | Length of the waiting packet |
| in_sent | input | 1 | Engine has sent the waiting packet |
| eng_addr | input | AW | Engine byte address |
| eng_rdata | output | 8 | Buffer byte at eng_addr |
| eng_we | input | 1 | Engine byte write (OUT data) |
| eng_wdata | input | 8 | Engine write byte |
| rx_done | input | 1 | Engine has received a good OUT packet |
| rx_count | input | PW | Byte count of that packet |
| rx_nak | output | 1 | OUT data would be refused |
| short_pkt | output | 1 | Last accepted OUT packet was short |

## Verification
The hardest state to reach is the queued zero-length packet. The stimulus has to program a transfer length that is an exact multiple of the max-packet size. It then fills and sends every full packet in turn, so that the last automatic send brings the length to exactly zero. The bench does this with the trailer enabled and again with it disabled. It also reaches the refused-packet state: it leaves a full OUT packet unread and then drives both an engine write and a new rx_done into it.

// File: rtl/ep_len_ctl.sv
module ep_len_ctl #(
  parameter int DEPTH = 64,
  parameter int LW    = 11,
  parameter int PW    = $clog2(DEPTH + 1),
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst,
  input  logic          cfg_dir_in,
  input  logic          cfg_no_zlp,
  input  logic          cfg_wide,
  input  logic          mps_we,
  input  logic [PW-1:0] mps_wdata,
  input  logic          len_we,
  input  logic [LW-1:0] len_wdata,
  output logic [LW-1:0] len_q,
  input  logic          cpu_we,
  input  logic [15:0]   cpu_wdata,
  input  logic          cpu_re,
  output logic [15:0]   cpu_rdata,
  input  logic          cmd_validate,
  input  logic          cmd_clear,
  output logic          tx_valid,
  output logic [PW-1:0] tx_len,
  input  logic          in_sent,
  input  logic [AW-1:0] eng_addr,
  output logic [7:0]    eng_rdata,
  input  logic          eng_we,
  input  logic [7:0]    eng_wdata,
  input  logic          rx_done,
  input  logic [PW-1:0] rx_count,
  output logic          rx_nak,
  output logic          short_pkt
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] mps_r, ptr, txl;
  logic [LW-1:0] blen;
  logic          txv, rxf, shrt, auto_pkt;

  wire           en    = mps_r != '0;
  wire           quiet = !bus_rst && !mps_we && !len_we;
  wire [PW-1:0]  step  = cfg_wide ? PW'(2) : PW'(1);
  wire [PW-1:0]  ptr_n = ptr + step;
  wire [LW-1:0]  mps_l = LW'(mps_r);
  wire [LW-1:0]  lim   = (blen != '0 && blen < mps_l) ? blen : mps_l;
  wire [LW-1:0]  ptr_l = LW'(ptr_n);
  wire           hit   = ptr_l >= lim;
  wire [LW-1:0]  cut   = (ptr_l < lim) ? ptr_l : lim;
  wire [LW-1:0]  txl_l = LW'(txl);
  wire [LW-1:0]  rem   = (blen > txl_l) ? blen - txl_l : '0;
  wire           zlp   = auto_pkt && txl == mps_r && blen != '0 && rem == '0 && !cfg_no_zlp;
  wire [PW-1:0]  mps_c = (mps_wdata > PW'(DEPTH)) ? PW'(DEPTH) : mps_wdata;
  wire [PW-1:0]  cnt_c = (rx_count > mps_r) ? mps_r : rx_count;
  wire           two   = cfg_wide && blen >= LW'(2);
  wire [PW-1:0]  take  = two ? PW'(2) : PW'(1);
  wire [AW-1:0]  pa    = ptr[AW-1:0];
  wire [AW-1:0]  pa1   = pa + AW'(1);

  wire send_ev = quiet && cfg_dir_in && in_sent && txv;
  wire wr_cpu  = quiet && cfg_dir_in && !send_ev && cpu_we && en && !txv;
  wire val_ev  = quiet && cfg_dir_in && !send_ev && !cpu_we && cmd_validate && en && !txv;
  wire clr_ev  = quiet && !cfg_dir_in && cmd_clear;
  wire rx_ev   = quiet && !cfg_dir_in && !cmd_clear && rx_done && en && !rxf;
  wire rd_ev   = quiet && !cfg_dir_in && !cmd_clear && !rx_ev && cpu_re && rxf;
  wire wr_eng  = quiet && !cfg_dir_in && eng_we && en && !rxf;

  always_ff @(posedge clk) begin
    if (wr_cpu) begin
      mem[pa] <= cpu_wdata[7:0];
      if (cfg_wide && ptr < PW'(DEPTH - 1)) mem[pa1] <= cpu_wdata[15:8];
    end
    if (wr_eng) mem[eng_addr] <= eng_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mps_r <= '0; blen <= '0; ptr <= '0; txl <= '0;
      txv <= 1'b0; rxf <= 1'b0; shrt <= 1'b0; auto_pkt <= 1'b0;
    end else if (bus_rst) begin
      blen <= '0; ptr <= '0; txv <= 1'b0; rxf <= 1'b0;
      shrt <= 1'b0; auto_pkt <= 1'b0;
    end else if (mps_we) begin
      mps_r <= mps_c; blen <= LW'(mps_c); ptr <= '0;
      txv <= 1'b0; rxf <= 1'b0; auto_pkt <= 1'b0;
    end else if (len_we) begin
      blen <= len_wdata;
    end else begin
      if (send_ev) begin
        blen <= rem;
        ptr  <= '0;
        txv  <= zlp;
        if (zlp) txl <= '0;
        auto_pkt <= 1'b0;
      end else if (wr_cpu) begin
        ptr <= ptr_n;
        if (hit) begin
          txv <= 1'b1; txl <= PW'(cut); auto_pkt <= 1'b1;
        end
      end else if (val_ev) begin
        txv <= 1'b1; txl <= ptr; auto_pkt <= 1'b0;
      end
      if (clr_ev) begin
        rxf <= 1'b0; blen <= '0; ptr <= '0;
      end else if (rx_ev) begin
        blen <= LW'(cnt_c);
        ptr  <= '0;
        rxf  <= cnt_c != '0;
        shrt <= rx_count < mps_r;
      end else if (rd_ev) begin
        blen <= blen - LW'(take);
        ptr  <= ptr + take;
        if (blen == LW'(take)) rxf <= 1'b0;
      end
    end
  end

  assign len_q     = blen;
  assign tx_valid  = txv;
  assign tx_len    = txl;
  assign short_pkt = shrt;
  assign rx_nak    = cfg_dir_in || !en || rxf;
  assign eng_rdata = mem[eng_addr];
  assign cpu_rdata = (!cfg_dir_in && rxf) ? (two ? {mem[pa1], mem[pa]} : {8'h00, mem[pa]}) : 16'h0000;

endmodule

module ep_len_ctl_chk #(
  parameter int DEPTH = 64,
  parameter int LW    = 11,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rst,
  input logic          cfg_dir_in,
  input logic          cfg_wide,
  input logic          mps_we,
  input logic [PW-1:0] mps_wdata,
  input logic          len_we,
  input logic [LW-1:0] len_q,
  input logic          cpu_re,
  input logic          cmd_clear,
  input logic          tx_valid,
  input logic [PW-1:0] tx_len,
  input logic          rx_done,
  input logic          rx_nak,
  input logic          short_pkt,
  input logic [PW-1:0] mps_r,
  input logic          rxf
);
  wire quiet = !bus_rst && !mps_we && !len_we;

  // R1
  bus_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (len_q == '0 && !tx_valid && !short_pkt));

  // R2
  mps_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mps_we && !bus_rst && mps_wdata <= PW'(DEPTH)) |=> len_q == LW'($past(mps_wdata)));

  // R4
  tx_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_len <= mps_r);

  // R3
  wide_read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !cfg_dir_in && cfg_wide && cpu_re && rxf && !cmd_clear && len_q >= LW'(2))
    |=> len_q == $past(len_q) - LW'(2));

  // R12
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !cfg_dir_in && rxf && rx_done && !cmd_clear && !cpu_re) |=> $stable(len_q));

  // R10
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_done && !bus_rst) |=> $stable(short_pkt));

  // R11
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mps_r == '0) |-> (!tx_valid && rx_nak));
endmodule

bind ep_len_ctl ep_len_ctl_chk #(.DEPTH(DEPTH), .LW(LW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cfg_dir_in(cfg_dir_in),
  .cfg_wide(cfg_wide), .mps_we(mps_we), .mps_wdata(mps_wdata), .len_we(len_we),
  .len_q(len_q), .cpu_re(cpu_re), .cmd_clear(cmd_clear), .tx_valid(tx_valid),
  .tx_len(tx_len), .rx_done(rx_done), .rx_nak(rx_nak), .short_pkt(short_pkt),
  .mps_r(mps_r), .rxf(rxf)
);

// File: tb/tb_ep_len_ctl.sv
module tb_ep_len_ctl;
  localparam int DEPTH = 64;
  localparam int LW = 11;
  localparam int PW = 7;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0, bus_rst = 0;
  logic cfg_dir_in = 1, cfg_no_zlp = 0, cfg_wide = 1;
  logic mps_we = 0, len_we = 0, cpu_we = 0, cpu_re = 0;
  logic cmd_validate = 0, cmd_clear = 0, in_sent = 0, eng_we = 0, rx_done = 0;
  logic [PW-1:0] mps_wdata = 0, rx_count = 0;
  logic [LW-1:0] len_wdata = 0;
  logic [15:0] cpu_wdata = 0;
  logic [AW-1:0] eng_addr = 0;
  logic [7:0] eng_wdata = 0;
  logic [LW-1:0] len_q;
  logic [15:0] cpu_rdata;
  logic tx_valid, rx_nak, short_pkt;
  logic [PW-1:0] tx_len;
  logic [7:0] eng_rdata;

  always #2.5 clk = ~clk;

  ep_len_ctl #(.DEPTH(DEPTH), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .cfg_dir_in(cfg_dir_in),
    .cfg_no_zlp(cfg_no_zlp), .cfg_wide(cfg_wide), .mps_we(mps_we),
    .mps_wdata(mps_wdata), .len_we(len_we), .len_wdata(len_wdata), .len_q(len_q),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
    .cmd_validate(cmd_validate), .cmd_clear(cmd_clear), .tx_valid(tx_valid),
    .tx_len(tx_len), .in_sent(in_sent), .eng_addr(eng_addr), .eng_rdata(eng_rdata),
    .eng_we(eng_we), .eng_wdata(eng_wdata), .rx_done(rx_done), .rx_count(rx_count),
    .rx_nak(rx_nak), .short_pkt(short_pkt)
  );

  int checks = 0, fails = 0;
  string cur = "R1";
  bit cmp_on = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mps, m_len, m_pos, m_txl;
  bit m_txv, m_full, m_short, m_auto;
  int m_mem[DEPTH];

  function automatic int m_rdata();
    if (cfg_dir_in || !m_full) return 0;
    if (cfg_wide && m_len >= 2) return m_mem[m_pos] + 256 * m_mem[m_pos + 1];
    return m_mem[m_pos];
  endfunction

  always @(posedge clk) begin
    int st, lim, rem, cnt, tk;
    bit z;
    if (!rst_n) begin
      m_mps = 0; m_len = 0; m_pos = 0; m_txl = 0;
      m_txv = 0; m_full = 0; m_short = 0; m_auto = 0;
    end else if (bus_rst) begin
      m_len = 0; m_pos = 0; m_txv = 0; m_full = 0; m_short = 0; m_auto = 0;
    end else if (mps_we) begin
      m_mps = (mps_wdata > DEPTH) ? DEPTH : int'(mps_wdata);
      m_len = m_mps; m_pos = 0; m_txv = 0; m_full = 0; m_auto = 0;
    end else if (len_we) begin
      m_len = len_wdata;
    end else if (cfg_dir_in) begin
      st = cfg_wide ? 2 : 1;
      if (in_sent && m_txv) begin
        rem = (m_len > m_txl) ? m_len - m_txl : 0;
        z = m_auto && m_txl == m_mps && m_len != 0 && rem == 0 && !cfg_no_zlp;
        m_len = rem; m_pos = 0; m_txv = z; m_auto = 0;
        if (z) m_txl = 0;
      end else if (cpu_we && m_mps != 0 && !m_txv) begin
        m_mem[m_pos] = cpu_wdata[7:0];
        if (cfg_wide && m_pos + 1 < DEPTH) m_mem[m_pos + 1] = cpu_wdata[15:8];
        m_pos += st;
        lim = (m_len != 0 && m_len < m_mps) ? m_len : m_mps;
        if (m_pos >= lim) begin
          m_txv = 1; m_txl = (m_pos < lim) ? m_pos : lim; m_auto = 1;
        end
      end else if (cmd_validate && m_mps != 0 && !m_txv) begin
        m_txv = 1; m_txl = m_pos; m_auto = 0;
      end
    end else begin
      if (eng_we && m_mps != 0 && !m_full) m_mem[eng_addr] = eng_wdata;
      if (cmd_clear) begin
        m_full = 0; m_len = 0; m_pos = 0;
      end else if (rx_done && m_mps != 0 && !m_full) begin
        cnt = (rx_count > m_mps) ? m_mps : int'(rx_count);
        m_len = cnt; m_pos = 0; m_full = cnt != 0; m_short = rx_count < m_mps;
      end else if (cpu_re && m_full) begin
        tk = (cfg_wide && m_len >= 2) ? 2 : 1;
        m_len -= tk; m_pos += tk;
        if (m_len == 0) m_full = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      chk(cur, "model len_q", int'(len_q), m_len);
      chk(cur, "model tx_valid", int'(tx_valid), int'(m_txv));
      if (m_txv) chk(cur, "model tx_len", int'(tx_len), m_txl);
      chk(cur, "model rx_nak", int'(rx_nak), int'(cfg_dir_in || m_mps == 0 || m_full));
      chk(cur, "model short_pkt", int'(short_pkt), int'(m_short));
      chk(cur, "model cpu_rdata", int'(cpu_rdata), m_rdata());
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic set_mps(int v); mps_we = 1; mps_wdata = PW'(v); tick(); mps_we = 0; endtask
  task automatic set_len(int v); len_we = 1; len_wdata = LW'(v); tick(); len_we = 0; endtask
  task automatic pwr(int d); cpu_we = 1; cpu_wdata = 16'(d); tick(); cpu_we = 0; endtask
  task automatic prd(); cpu_re = 1; tick(); cpu_re = 0; endtask
  task automatic send(); in_sent = 1; tick(); in_sent = 0; endtask
  task automatic valid(); cmd_validate = 1; tick(); cmd_validate = 0; endtask
  task automatic clear(); cmd_clear = 1; tick(); cmd_clear = 0; endtask
  task automatic brst(); bus_rst = 1; tick(); bus_rst = 0; endtask
  task automatic eput(int a, int d);
    eng_we = 1; eng_addr = AW'(a); eng_wdata = 8'(d); tick(); eng_we = 0;
  endtask
  task automatic rxd(int n); rx_done = 1; rx_count = PW'(n); tick(); rx_done = 0; endtask
  task automatic fill8();
    for (int i = 0; i < 4; i++) pwr(((2 * i + 2) << 8) | (2 * i + 1));
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    cmp_on = 1;
    chk("R1", "reset len_q", int'(len_q), 0);
    chk("R1", "reset tx_valid", int'(tx_valid), 0);
    chk("R1", "reset short_pkt", int'(short_pkt), 0);

    cur = "R2"; set_mps(100);
    chk("R2", "clipped mps reload", int'(len_q), 64);
    set_mps(8);
    chk("R2", "mps reload", int'(len_q), 8);
    set_len(20);
    chk("R2", "length write", int'(len_q), 20);

    cur = "R4";
    for (int i = 0; i < 3; i++) pwr(((2 * i + 2) << 8) | (2 * i + 1));
    chk("R4", "no validate before boundary", int'(tx_valid), 0);
    pwr(16'h0807);
    chk("R4", "auto validate", int'(tx_valid), 1);
    chk("R4", "full packet length", int'(tx_len), 8);
    eng_addr = 0; #1;
    chk("R3", "low lane at lower address", int'(eng_rdata), 1);
    eng_addr = 1; #1;
    chk("R3", "high lane at next address", int'(eng_rdata), 2);
    pwr(16'hFFFF);
    chk("R4", "write while pending ignored", int'(tx_len), 8);
    eng_addr = 0; #1;
    chk("R4", "pending data kept", int'(eng_rdata), 1);

    cur = "R5"; send();
    chk("R5", "length after send", int'(len_q), 12);
    chk("R5", "tx_valid after send", int'(tx_valid), 0);
    fill8(); send();
    chk("R5", "length after second send", int'(len_q), 4);
    pwr(16'h0201);
    chk("R5", "short not yet valid", int'(tx_valid), 0);
    pwr(16'h0403);
    chk("R5", "short packet valid", int'(tx_valid), 1);
    chk("R5", "short packet length", int'(tx_len), 4);
    send();
    chk("R6", "no trailer after short", int'(tx_valid), 0);
    chk("R5", "transfer done", int'(len_q), 0);

    cur = "R6"; set_len(16);
    fill8(); send(); fill8(); send();
    chk("R6", "zero-length queued", int'(tx_valid), 1);
    chk("R6", "zero-length size", int'(tx_len), 0);
    send();
    chk("R6", "after zero-length", int'(tx_valid), 0);
    cfg_no_zlp = 1; set_len(8);
    fill8(); send();
    chk("R6", "trailer suppressed", int'(tx_valid), 0);
    chk("R6", "length zero", int'(len_q), 0);

    cur = "R7"; cfg_no_zlp = 0; cfg_wide = 0;
    pwr(16'h00A1); pwr(16'h00A2); pwr(16'h00A3);
    chk("R3", "narrow writes no validate", int'(tx_valid), 0);
    valid();
    chk("R7", "manual validate", int'(tx_valid), 1);
    chk("R3", "narrow count", int'(tx_len), 3);
    eng_addr = 2; #1;
    chk("R3", "narrow byte placement", int'(eng_rdata), 8'hA3);
    send();

    cur = "R11"; set_mps(0);
    pwr(16'h1111); valid();
    chk("R11", "disabled no validate", int'(tx_valid), 0);
    cfg_dir_in = 0; tick();
    chk("R11", "disabled nak", int'(rx_nak), 1);
    rxd(4);
    chk("R11", "disabled rx ignored", int'(len_q), 0);

    cur = "R8"; cfg_wide = 1; set_mps(8);
    clear();
    chk("R8", "empty OUT no nak", int'(rx_nak), 0);
    eput(0, 8'h11); eput(1, 8'h22); eput(2, 8'h33); eput(3, 8'h44); eput(4, 8'h55);
    rxd(5);
    chk("R8", "count loaded", int'(len_q), 5);
    chk("R12", "nak while full", int'(rx_nak), 1);
    chk("R10", "short flag set", int'(short_pkt), 1);
    chk("R9", "first word", int'(cpu_rdata), 16'h2211);
    prd();
    chk("R8", "count after wide read", int'(len_q), 3);
    chk("R9", "second word", int'(cpu_rdata), 16'h4433);
    prd();
    chk("R9", "odd byte low lane", int'(cpu_rdata), 16'h0055);
    prd();
    chk("R8", "auto clear count", int'(len_q), 0);
    chk("R8", "auto clear nak", int'(rx_nak), 0);
    chk("R9", "empty read data", int'(cpu_rdata), 0);

    cur = "R12";
    for (int i = 0; i < 8; i++) eput(i, 8'hA0 + i);
    rxd(8);
    chk("R10", "full packet not short", int'(short_pkt), 0);
    eput(0, 8'hEE); rxd(3);
    chk("R12", "refused count", int'(len_q), 8);
    chk("R12", "refused short flag", int'(short_pkt), 0);
    chk("R12", "refused data", int'(cpu_rdata), 16'hA1A0);
    cur = "R7"; clear();
    chk("R7", "clear count", int'(len_q), 0);
    chk("R7", "clear nak", int'(rx_nak), 0);

    cur = "R3"; cfg_wide = 0;
    eput(0, 8'h5A); eput(1, 8'h6B); rxd(2);
    chk("R10", "two-byte packet short", int'(short_pkt), 1);
    chk("R3", "narrow first byte", int'(cpu_rdata), 8'h5A);
    prd();
    chk("R3", "narrow step", int'(len_q), 1);
    chk("R3", "narrow second byte", int'(cpu_rdata), 8'h6B);
    prd();
    chk("R8", "narrow auto clear", int'(rx_nak), 0);

    cur = "R1"; rxd(3); brst();
    chk("R1", "bus reset length", int'(len_q), 0);
    chk("R1", "bus reset nak", int'(rx_nak), 0);
    chk("R1", "bus reset short", int'(short_pkt), 0);
    rxd(8);
    chk("R1", "mps kept over bus reset", int'(short_pkt), 0);
    chk("R1", "mps kept count", int'(len_q), 8);
    tick();
    cmp_on = 0;
    finish_sim();
  end
endmodule